// File: doc/BRIEF.md
# Two-Bit Branch History Table

The block is a direct-mapped table of two-bit branch predictors. A fetch stage presents a branch PC on the lookup port and gets a taken/not-taken guess back in the same cycle. Later, when the branch resolves, the execute stage presents the same PC with the real outcome on the update port. The matching entry then moves according to one of two transition rules at the next clock edge.

Entries carry no tag, so branches whose PCs share the index bits share one predictor. A configuration input selects the transition rule that each update uses. The first rule is a plain saturating up/down counter. The second is a hysteresis rule in which a weak state that guesses wrong jumps to the strong state of the other direction.

Top module: `bht_predictor`

## Requirements
- R1: After reset every entry holds weak not-taken (code 1), so every lookup predicts not-taken until an update touches its entry.
- R2: The entry index is `pc[IDX_LSB+IDX_W-1:IDX_LSB]` (bits 8..2 by default, IDX_W = log2 of ENTRIES = 128). PCs that differ only outside those bits share one entry.
- R3: `lk_taken` is a combinational function of `lk_pc` and the stored table, available in the same cycle. It is 1 exactly when the entry code is 2 (weak taken) or 3 (strong taken). Codes 0 and 1 are strong and weak not-taken.
- R4: The table changes only at a rising clock edge with `up_valid` high. With `up_valid` low, no prediction changes, whatever `up_pc`, `up_taken` or `cfg_hyst` do.
- R5: An update changes only the entry selected by `up_pc`. The predictions of all other indices stay the same.
- R6: When a lookup and an update address the same index in the same cycle, the lookup returns the value from before the update.
- R7: With `cfg_hyst` = 0, a taken outcome adds 1 to the code, stopping at 3. A not-taken outcome subtracts 1, stopping at 0.
- R8: With `cfg_hyst` = 1, transitions are as follows. A strong state that mispredicts becomes the weak state on the same side. A weak state that mispredicts becomes the strong state on the opposite side. A weak state that predicts correctly becomes the strong state on its own side. A strong state that predicts correctly stays where it is.
- R9: `cfg_hyst` is sampled with each update, so successive updates to one entry may follow different rules.
- R10: Under either rule, an update whose outcome matches the current prediction of that entry leaves the prediction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hyst | input | 1 | Rule select: 0 saturating counter, 1 hysteresis |
| lk_pc | input | PC_W | Branch PC looked up at fetch |
| lk_taken | output | 1 | Prediction for `lk_pc`, 1 = taken |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench targets the sequences where the two rules part ways. After two taken and two not-taken outcomes, a single taken outcome predicts taken under the counter rule but not-taken under hysteresis, so a design that swapped or merged the rules would give the wrong guess. Same-cycle lookup and update on one index catch a write-through read path, which would return the new value early. Aliased PCs catch an index taken from the wrong bits. Switching `cfg_hyst` between updates to one entry catches a rule latched once instead of sampled on each update.

// File: rtl/bht_pkg.sv
package bht_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'd0;
    localparam ctr_t CTR_WNT = 2'd1;
    localparam ctr_t CTR_WT  = 2'd2;
    localparam ctr_t CTR_ST  = 2'd3;

    typedef enum logic {
        POL_SAT  = 1'b0,
        POL_HYST = 1'b1
    } policy_e;
endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 7,
    parameter int IDX_LSB = 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    assign idx = pc[IDX_LSB +: IDX_W];
endmodule

// File: rtl/bht_ctr_next.sv
module bht_ctr_next
    import bht_pkg::*;
(
    input  policy_e policy,
    input  ctr_t    cur,
    input  logic    taken,
    output ctr_t    nxt
);
    always_comb begin
        nxt = cur;
        if (policy == POL_SAT) begin
            if (taken && cur != CTR_ST)
                nxt = cur + 2'd1;
            else if (!taken && cur != CTR_SNT)
                nxt = cur - 2'd1;
        end else begin
            unique case (cur)
                CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
                CTR_WT:  nxt = taken ? CTR_ST  : CTR_SNT;
                CTR_WNT: nxt = taken ? CTR_ST  : CTR_SNT;
                default: nxt = taken ? CTR_WNT : CTR_SNT;
            endcase
        end
    end
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
    import bht_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 128,
    parameter int IDX_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_hyst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] tbl;
    } bht_state_t;

    bht_state_t state_d, state_q;
    logic [IDX_W-1:0] lk_idx, up_idx;
    ctr_t up_cur, up_nxt;
    policy_e policy;

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_lk_idx (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bht_index #(.PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_up_idx (
        .pc  (up_pc),
        .idx (up_idx)
    );

    assign policy = cfg_hyst ? POL_HYST : POL_SAT;
    assign up_cur = state_q.tbl[up_idx];

    bht_ctr_next u_next (
        .policy (policy),
        .cur    (up_cur),
        .taken  (up_taken),
        .nxt    (up_nxt)
    );

    // Read from the registered table: a same-cycle update is not yet visible.
    assign lk_taken = state_q.tbl[lk_idx][1];

    always_comb begin
        state_d = state_q;
        if (up_valid)
            state_d.tbl[up_idx] = up_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q.tbl <= {ENTRIES{CTR_WNT}};
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 128,
    parameter int IDX_LSB = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_hyst,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_taken,
    input logic            up_valid,
    input logic [PC_W-1:0] up_pc,
    input logic            up_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] lk_i, up_i;
    assign lk_i = lk_pc[IDX_LSB +: IDX_W];
    assign up_i = up_pc[IDX_LSB +: IDX_W];

    AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(lk_taken)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> (!$stable(lk_pc) || $stable(lk_taken))); // R4

    AST_OTHER_INDEX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_i != lk_i) |=> (!$stable(lk_pc) || $stable(lk_taken))); // R5

    AST_CORRECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_i == lk_i && up_taken == lk_taken)
        |=> (!$stable(lk_pc) || $stable(lk_taken))); // R10

    AST_TAKEN_NEVER_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_i == lk_i && up_taken && lk_taken)
        |=> (!$stable(lk_pc) || lk_taken)); // R7
endmodule

bind bht_predictor bht_checker #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)
) u_chk (.*);

// File: tb/sim_bht_predictor.sv
`timescale 1ns/1ps
module sim_bht_predictor;
    localparam int PC_W = 32;
    localparam int ENTRIES = 128;
    localparam int IDX_LSB = 2;
    localparam int IDX_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_hyst = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic lk_taken;
    logic up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic up_taken = 1'b0;

    int n_tests = 0;
    int n_fail = 0;
    logic [1:0] model [ENTRIES];

    always #5 clk = ~clk;

    bht_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_hyst(cfg_hyst), .lk_pc(lk_pc),
        .lk_taken(lk_taken), .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_LSB +: IDX_W]);
    endfunction

    // Expected next code from R7 (counter) and R8 (hysteresis).
    function automatic logic [1:0] exp_next(input logic hyst, input logic [1:0] s, input logic t);
        if (!hyst) begin
            if (t) return (s == 2'd3) ? 2'd3 : s + 2'd1;
            return (s == 2'd0) ? 2'd0 : s - 2'd1;
        end
        case (s)
            2'd3: return t ? 2'd3 : 2'd2;
            2'd2: return t ? 2'd3 : 2'd0;
            2'd1: return t ? 2'd3 : 2'd0;
            default: return t ? 2'd1 : 2'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lk_pc=%h lk_taken=%b expected %b", tag, lk_pc, act, exp);
        end
    endtask

    // Drive at negedge, check the combinational prediction, then let the edge apply.
    task automatic step(input string tag, input logic [PC_W-1:0] lpc, input logic v,
                        input logic [PC_W-1:0] upc, input logic t, input logic h);
        @(negedge clk);
        lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t; cfg_hyst = h;
        #1;
        check(tag, lk_taken, model[idx_of(lpc)][1]);
        @(posedge clk);
        if (v) model[idx_of(upc)] = exp_next(h, model[idx_of(upc)], t);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] a;
        void'($urandom(32'h5eed_0b17));
        for (int i = 0; i < ENTRIES; i++) model[i] = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state predicts not-taken everywhere.
        step("R1", 32'h0000_0000, 1'b0, '0, 1'b0, 1'b0);
        step("R1", 32'h0000_01FC, 1'b0, '0, 1'b0, 1'b0);
        step("R1", 32'hDEAD_BEE0, 1'b0, '0, 1'b0, 1'b0);

        // R7 vs R8: T,T,N,N,T on one entry under each rule.
        a = 32'h0000_0040;
        step("R7", a, 1'b1, a, 1'b1, 1'b0);
        step("R7", a, 1'b1, a, 1'b1, 1'b0);
        step("R7", a, 1'b1, a, 1'b0, 1'b0);
        step("R7", a, 1'b1, a, 1'b0, 1'b0);
        step("R7", a, 1'b1, a, 1'b1, 1'b0);
        step("R7", a, 1'b0, a, 1'b0, 1'b0);
        check("R7 saturating after T,T,N,N,T", lk_taken, 1'b1);
        a = 32'h0000_0080;
        step("R8", a, 1'b1, a, 1'b1, 1'b1);
        step("R8", a, 1'b1, a, 1'b1, 1'b1);
        step("R8", a, 1'b1, a, 1'b0, 1'b1);
        step("R8", a, 1'b1, a, 1'b0, 1'b1);
        step("R8", a, 1'b1, a, 1'b1, 1'b1);
        step("R8", a, 1'b0, a, 1'b0, 1'b1);
        check("R8 hysteresis after T,T,N,N,T", lk_taken, 1'b0);

        // R6: same-cycle lookup and update see the old value.
        a = 32'h0000_00C0;
        step("R6", a, 1'b1, a, 1'b1, 1'b0);
        step("R6", a, 1'b0, a, 1'b0, 1'b0);

        // R2 alias and R5 neighbour.
        step("R2", 32'h1000_0210, 1'b1, 32'h0000_0010, 1'b1, 1'b0);
        step("R2", 32'h1000_0210, 1'b0, '0, 1'b0, 1'b0);
        check("R2 aliased pc", lk_taken, 1'b1);
        step("R5", 32'h0000_0014, 1'b0, '0, 1'b0, 1'b0);
        check("R5 neighbour untouched", lk_taken, 1'b0);

        // R4: no strobe, busy other inputs.
        step("R4", 32'h0000_0100, 1'b0, 32'h0000_0100, 1'b1, 1'b1);
        step("R4", 32'h0000_0100, 1'b0, 32'h0000_0100, 1'b1, 1'b0);
        check("R4 ignored update", lk_taken, 1'b0);

        // R9: switch rules between updates to one entry.
        a = 32'h0000_0140;
        step("R9", a, 1'b1, a, 1'b1, 1'b0);
        step("R9", a, 1'b1, a, 1'b0, 1'b1);
        step("R9", a, 1'b1, a, 1'b1, 1'b0);
        step("R9", a, 1'b0, '0, 1'b0, 1'b0);
        check("R9 mixed rules", lk_taken, 1'b0);

        // R10 and random mix over a few indices to force collisions.
        for (int k = 0; k < 3000; k++) begin
            logic [PC_W-1:0] lp, upp;
            logic h;
            lp  = {$urandom} & 32'hFFFF_F01C;
            upp = ($urandom_range(0, 3) == 0) ? lp : ({$urandom} & 32'hFFFF_F01C);
            h   = 1'($urandom);
            step(h ? "R8 random" : "R7 random", lp, 1'($urandom), upp, 1'($urandom), h);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule